// File: doc/BRIEF.md
# External Bus Width Access Splitter

This block sits between a processor-side access port and an external memory or peripheral bus that is narrower than the processor data path. A single host access can be a byte, a 16-bit word or a 32-bit longword. When the access is wider than the external port, the block breaks it into a series of external beats at rising addresses, with the least significant data going out first. The external port width is picked per access by a configuration input, and it is either 16 or 8 bits.

Every beat drives an address, a 16-bit data bus, an active-low strobe for each of the two byte lanes and a write flag. The beat is held under a request/acknowledge handshake, so a slow device can stretch it for as long as it needs. For a read, each beat's returned lanes are written into the matching bytes of a 32-bit result. The host sees a one-cycle completion pulse once the final beat has been acknowledged. The block takes a new host request only while it is idle. A misaligned request, or one with the reserved size code, is refused with a one-cycle error pulse, and it produces no external activity.

Top module: `ext_bus_splitter`

## Requirements
- R1: While reset is applied, and after it is released, `ext_req`, `host_done`, `host_err` and `host_busy` are low and `ext_be_n` is 2'b11.
- R2: Port width 16 (`cfg_narrow`=0), size code 2'b00 (byte): exactly one beat at the host address. An even address drives `ext_be_n`=2'b10 (bit 0 is the lower lane [7:0], active low) with data byte [7:0] on the lower lane. An odd address drives `ext_be_n`=2'b01 with that byte on the upper lane [15:8]. The unused lane is zero.
- R3: Port width 16, size code 2'b01 (word) at an even address: exactly one beat with `ext_be_n`=2'b00 and `ext_wdata` = host data [15:0].
- R4: Port width 16, size code 2'b10 (longword) at an address that is a multiple of 4: two beats with `ext_be_n`=2'b00. The first is at A with data [15:0] and the second is at A+2 with data [31:16].
- R5: Port width 8 (`cfg_narrow`=1): every beat drives `ext_be_n`=2'b10 and zero on `ext_wdata[15:8]`.
- R6: Port width 8, word at even address n: two beats, at n carrying data [7:0] and at n+1 carrying data [15:8].
- R7: Port width 8, longword at A: four beats at A, A+1, A+2 and A+3, carrying data bytes [7:0], [15:8], [23:16] and [31:24] in that order.
- R8: Port width 8, byte access at any address: exactly one beat at that address, carrying data [7:0].
- R9: For a read, the lanes of each acknowledged beat land in the host result bytes that the beat covers. A byte read returns in [7:0] and a word read in [15:0]. Result bytes that no beat covers read as zero.
- R10: `host_done` is high for exactly one cycle, the cycle right after the clock edge at which the last beat's `ext_ack` is sampled high.
- R11: While `ext_req` is high and `ext_ack` is low, `ext_req`, `ext_addr`, `ext_be_n`, `ext_wr` and `ext_wdata` keep their values into the next cycle.
- R12: `host_busy` is high from acceptance until completion. A request presented during that time is ignored and causes no extra beats.
- R13: A word at an odd address, a longword at an address that is not a multiple of 4, and size code 2'b11 each produce a one-cycle `host_err` in the cycle after acceptance, with no beat issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_narrow | input | 1 | External port width for the next accepted access: 1 = 8-bit, 0 = 16-bit |
| host_req | input | 1 | Host access request, taken when idle |
| host_addr | input | ADDR_W | Host byte address |
| host_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Host write data, least significant byte first on the bus |
| host_busy | output | 1 | Access in progress, requests ignored |
| host_rdata | output | 32 | Assembled read data, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | One-cycle misalignment/reserved-size error pulse |
| ext_req | output | 1 | Beat request, held until acknowledged |
| ext_addr | output | ADDR_W | Beat byte address |
| ext_wr | output | 1 | Beat is a write |
| ext_wdata | output | 16 | Beat write data, upper and lower lanes |
| ext_be_n | output | 2 | Active-low lane strobes, bit 1 upper, bit 0 lower |
| ext_rdata | input | 16 | Beat read data from the device |
| ext_ack | input | 1 | Beat acknowledge |

## Verification
The embedded assertions check the following on every cycle: beat outputs hold steady while acknowledge is pending, an 8-bit port stays on its lower lane, a 16-bit byte beat asserts exactly one strobe, no beat is ever issued for a misaligned access, completion is a single pulse that follows an acknowledged beat, and the beat index never runs past the planned count. The beat sequence itself is left to the bench. Its scenarios show the beat addresses, the lane data order, the assembled read bytes, the timing of completion under added wait cycles, and that a request arriving while busy is dropped.

// File: rtl/split_pkg.sv
package split_pkg;
  localparam int unsigned HOST_BYTES = 4;
  localparam int unsigned EXT_BYTES  = 2;
  localparam int unsigned HOST_DW    = HOST_BYTES * 8;
  localparam int unsigned EXT_DW     = EXT_BYTES * 8;
  localparam int unsigned BEAT_W     = $clog2(HOST_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BEAT  = 2'b01,
    ST_DONE  = 2'b10,
    ST_FAULT = 2'b11
  } seq_state_e;
endpackage

// File: rtl/split_decode.sv
module split_decode
  import split_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        addr_lo,
  input  logic              narrow,
  output logic              fault,
  output logic [BEAT_W-1:0] last_beat
);
  always_comb begin
    fault     = 1'b0;
    last_beat = '0;
    case (acc_size_e'(size))
      SZ_BYTE: begin
        last_beat = '0;
      end
      SZ_WORD: begin
        fault     = addr_lo[0];
        last_beat = narrow ? BEAT_W'(1) : BEAT_W'(0);
      end
      SZ_LONG: begin
        fault     = |addr_lo;
        last_beat = narrow ? BEAT_W'(3) : BEAT_W'(1);
      end
      default: begin
        fault = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/split_seq.sv
module split_seq
  import split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_fault,
  input  logic [BEAT_W-1:0] host_last,
  input  logic              ext_ack,
  output seq_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              capture_en,
  output logic              beat_ack
);
  seq_state_e        state_d;
  logic [BEAT_W-1:0] beat_d;
  logic [BEAT_W-1:0] last_q, last_d;
  logic              final_beat;

  assign capture_en = (state == ST_IDLE) && host_req;
  assign beat_ack   = (state == ST_BEAT) && ext_ack;
  assign final_beat = (beat == last_q);

  always_comb begin
    state_d = state;
    beat_d  = beat;
    last_d  = last_q;
    case (state)
      ST_IDLE: begin
        if (capture_en) begin
          state_d = host_fault ? ST_FAULT : ST_BEAT;
          beat_d  = '0;
          last_d  = host_last;
        end
      end
      ST_BEAT: begin
        if (beat_ack) begin
          if (final_beat) state_d = ST_DONE;
          else            beat_d  = beat + BEAT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      beat   <= '0;
      last_q <= '0;
    end else begin
      state  <= state_d;
      beat   <= beat_d;
      last_q <= last_d;
    end
  end

  assert_beat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BEAT) |-> (beat <= last_q));

  assert_wait_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BEAT && !ext_ack) |=> (state == ST_BEAT && $stable(beat)));

  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BEAT && !ext_ack && host_req) |=> $stable(last_q));
endmodule

// File: rtl/split_lane.sv
module split_lane
  import split_pkg::*;
(
  input  logic                narrow,
  input  logic [1:0]          size,
  input  logic                addr_odd,
  input  logic [BEAT_W-1:0]   beat,
  input  logic [HOST_DW-1:0]  wdata,
  input  logic [EXT_DW-1:0]   rd_bus,
  output logic [BEAT_W-1:0]   offset,
  output logic [1:0]          be_n,
  output logic [EXT_DW-1:0]   wbus,
  output logic [HOST_DW-1:0]  rd_bytes,
  output logic [HOST_BYTES-1:0] rd_mask
);
  logic [4:0] byte_sh;
  logic [4:0] half_sh;

  assign byte_sh = {beat, 3'b000};
  assign half_sh = {beat[0], 4'b0000};

  always_comb begin
    offset   = '0;
    be_n     = 2'b11;
    wbus     = '0;
    rd_bytes = '0;
    rd_mask  = '0;
    if (narrow) begin
      offset    = beat;
      be_n      = 2'b10;
      wbus[7:0] = 8'(wdata >> byte_sh);
      rd_bytes  = HOST_DW'(rd_bus[7:0]) << byte_sh;
      rd_mask   = HOST_BYTES'(1) << beat;
    end else if (acc_size_e'(size) == SZ_BYTE) begin
      rd_mask = HOST_BYTES'(1);
      if (addr_odd) begin
        be_n          = 2'b01;
        wbus[15:8]    = wdata[7:0];
        rd_bytes[7:0] = rd_bus[15:8];
      end else begin
        be_n          = 2'b10;
        wbus[7:0]     = wdata[7:0];
        rd_bytes[7:0] = rd_bus[7:0];
      end
    end else begin
      offset   = {beat[0], 1'b0};
      be_n     = 2'b00;
      wbus     = EXT_DW'(wdata >> half_sh);
      rd_bytes = HOST_DW'(rd_bus) << half_sh;
      rd_mask  = HOST_BYTES'(3) << {beat[0], 1'b0};
    end
  end
endmodule

// File: rtl/split_gather.sv
module split_gather
  import split_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  load,
  input  logic [HOST_BYTES-1:0] mask,
  input  logic [HOST_DW-1:0]    bytes_in,
  output logic [HOST_DW-1:0]    result
);
  for (genvar i = 0; i < HOST_BYTES; i++) begin : g_byte
    logic [7:0] q, d;
    always_comb begin
      d = q;
      if (clear)                d = '0;
      else if (load && mask[i]) d = bytes_in[i*8 +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign result[i*8 +: 8] = q;
  end

  assert_load_has_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (mask != '0));

  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (result == '0));
endmodule

// File: rtl/ext_bus_splitter.sv
module ext_bus_splitter
  import split_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic              host_busy,
  output logic [31:0]       host_rdata,
  output logic              host_done,
  output logic              host_err,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_wr,
  output logic [15:0]       ext_wdata,
  output logic [1:0]        ext_be_n,
  input  logic [15:0]       ext_rdata,
  input  logic              ext_ack
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic              dec_fault;
  logic [BEAT_W-1:0] dec_last;

  split_decode u_decode (
    .size      (host_size),
    .addr_lo   (host_addr[1:0]),
    .narrow    (cfg_narrow),
    .fault     (dec_fault),
    .last_beat (dec_last)
  );

  seq_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              capture_en;
  logic              beat_ack;

  split_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_req   (host_req),
    .host_fault (dec_fault),
    .host_last  (dec_last),
    .ext_ack    (ext_ack),
    .state      (state),
    .beat       (beat),
    .capture_en (capture_en),
    .beat_ack   (beat_ack)
  );

  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [1:0]         size_q, size_d;
  logic               wr_q, wr_d;
  logic               narrow_q, narrow_d;
  logic [HOST_DW-1:0] wdata_q, wdata_d;

  always_comb begin
    addr_d   = addr_q;
    size_d   = size_q;
    wr_d     = wr_q;
    narrow_d = narrow_q;
    wdata_d  = wdata_q;
    if (capture_en) begin
      addr_d   = host_addr;
      size_d   = host_size;
      wr_d     = host_wr;
      narrow_d = cfg_narrow;
      wdata_d  = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q   <= '0;
      size_q   <= '0;
      wr_q     <= 1'b0;
      narrow_q <= 1'b0;
      wdata_q  <= '0;
    end else begin
      addr_q   <= addr_d;
      size_q   <= size_d;
      wr_q     <= wr_d;
      narrow_q <= narrow_d;
      wdata_q  <= wdata_d;
    end
  end

  logic [BEAT_W-1:0]     lane_off;
  logic [1:0]            lane_be_n;
  logic [EXT_DW-1:0]     lane_wbus;
  logic [HOST_DW-1:0]    lane_rbytes;
  logic [HOST_BYTES-1:0] lane_rmask;

  split_lane u_lane (
    .narrow   (narrow_q),
    .size     (size_q),
    .addr_odd (addr_q[0]),
    .beat     (beat),
    .wdata    (wdata_q),
    .rd_bus   (ext_rdata),
    .offset   (lane_off),
    .be_n     (lane_be_n),
    .wbus     (lane_wbus),
    .rd_bytes (lane_rbytes),
    .rd_mask  (lane_rmask)
  );

  split_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (capture_en),
    .load     (beat_ack && !wr_q),
    .mask     (lane_rmask),
    .bytes_in (lane_rbytes),
    .result   (host_rdata)
  );

  assign ext_req   = (state == ST_BEAT);
  assign ext_addr  = addr_q + ADDR_W'(lane_off);
  assign ext_wr    = ext_req && wr_q;
  assign ext_wdata = (ext_req && wr_q) ? lane_wbus : '0;
  assign ext_be_n  = ext_req ? lane_be_n : 2'b11;
  assign host_busy = (state != ST_IDLE);
  assign host_done = (state == ST_DONE);
  assign host_err  = (state == ST_FAULT);

  assert_hold_beat_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_be_n)
                               && $stable(ext_wdata) && $stable(ext_wr)));

  assert_narrow_lane_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_req && narrow_q) |-> (ext_be_n == 2'b10 && ext_wdata[15:8] == 8'h00));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_req && !narrow_q && size_q == 2'b00) |-> ($countones(ext_be_n) == 1));

  assert_no_misaligned_beat_R13: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_req |-> !((size_q == 2'b01 && addr_q[0]) || (size_q == 2'b10 && addr_q[1:0] != 2'b00)
                  || size_q == 2'b11));

  assert_err_no_beat_R13: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_err |-> (!ext_req && $past(host_req && !host_busy)));

  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_done |-> $past(ext_req && ext_ack));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_done |=> !host_done);
endmodule

// File: tb/ext_bus_splitter_bench.sv
module ext_bus_splitter_bench;
  localparam int AW = 32;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_narrow, host_req, host_wr, ext_ack;
  logic [AW-1:0] host_addr;
  logic [1:0]    host_size;
  logic [31:0]   host_wdata;
  logic          host_busy, host_done, host_err, ext_req, ext_wr;
  logic [31:0]   host_rdata;
  logic [AW-1:0] ext_addr;
  logic [15:0]   ext_wdata, ext_rdata;
  logic [1:0]    ext_be_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ext_bus_splitter #(.ADDR_W(AW)) u_ext_bus_splitter (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .host_req(host_req),
    .host_addr(host_addr), .host_size(host_size), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_busy(host_busy), .host_rdata(host_rdata),
    .host_done(host_done), .host_err(host_err), .ext_req(ext_req),
    .ext_addr(ext_addr), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .ext_be_n(ext_be_n), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
  );

  // fields: narrow[45] size[44:43] addr[42:35] wr[34] wdata[33:2] waits[1:0]
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h40, 1'b1, 32'h1122_33A5, 2'd0},
    {1'b0, 2'd0, 8'h43, 1'b1, 32'h1122_335C, 2'd1},
    {1'b0, 2'd0, 8'h41, 1'b0, 32'h0000_0000, 2'd0},
    {1'b0, 2'd1, 8'h42, 1'b1, 32'hDEAD_BEEF, 2'd1},
    {1'b0, 2'd1, 8'h40, 1'b0, 32'h0000_0000, 2'd0},
    {1'b0, 2'd2, 8'h44, 1'b1, 32'hCAFE_F00D, 2'd2},
    {1'b0, 2'd2, 8'h48, 1'b0, 32'h0000_0000, 2'd1},
    {1'b1, 2'd0, 8'h4B, 1'b1, 32'h9988_7766, 2'd0},
    {1'b1, 2'd0, 8'h4A, 1'b0, 32'h0000_0000, 2'd2},
    {1'b1, 2'd1, 8'h42, 1'b1, 32'h0000_A1B2, 2'd0},
    {1'b1, 2'd1, 8'h4C, 1'b0, 32'h0000_0000, 2'd1},
    {1'b1, 2'd2, 8'h50, 1'b1, 32'h0403_0201, 2'd3},
    {1'b1, 2'd2, 8'h54, 1'b0, 32'h0000_0000, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_word(input logic [AW-1:0] a);
    return {a[7:0] + 8'h11, a[7:0] ^ 8'hC3};
  endfunction

  function automatic int beats_of(input logic n, input logic [1:0] s);
    if (n) return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    return (s == 2'd2) ? 2 : 1;
  endfunction

  function automatic string tag_of(input logic n, input logic [1:0] s);
    if (n) return (s == 2'd0) ? "R8" : (s == 2'd1) ? "R6" : "R7";
    return (s == 2'd0) ? "R2" : (s == 2'd1) ? "R3" : "R4";
  endfunction

  task automatic run_access(input logic n, input logic [1:0] s, input logic [AW-1:0] a,
                            input logic w, input logic [31:0] wd, input int waits);
    string tg;
    int nb;
    logic [AW-1:0] ea;
    logic [1:0] eb;
    logic [15:0] ew, rw;
    logic [31:0] er;
    tg = tag_of(n, s);
    nb = beats_of(n, s);
    er = '0;
    @(negedge clk);
    cfg_narrow = n; host_size = s; host_addr = a; host_wr = w; host_wdata = wd; host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    for (int k = 0; k < nb; k++) begin
      ea = n ? a + AW'(k) : a + AW'(2 * k);
      if (n)             eb = 2'b10;
      else if (s == 2'd0) eb = a[0] ? 2'b01 : 2'b10;
      else               eb = 2'b00;
      if (n)             ew = {8'h00, 8'(wd >> (8 * k))};
      else if (s == 2'd0) ew = a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
      else               ew = 16'(wd >> (16 * k));
      if (!w) ew = 16'h0000;
      check({tg, " beat req"}, 32'(ext_req), 32'd1);
      check({tg, " beat addr"}, ext_addr, ea);
      check({tg, " strobes"}, 32'(ext_be_n), 32'(eb));
      check({tg, " wdata"}, 32'(ext_wdata), 32'(ew));
      if (n) check("R5 upper lane idle", 32'({ext_be_n, ext_wdata[15:8]}), 32'({2'b10, 8'h00}));
      check("R10 no early done", 32'(host_done), 32'd0);
      for (int j = 0; j < waits; j++) begin
        @(negedge clk);
        check("R11 hold addr", ext_addr, ea);
        check("R11 hold req/strobe/data", 32'({ext_req, ext_be_n, ext_wdata}), 32'({1'b1, eb, ew}));
      end
      rw = dev_word(ea);
      if (n)             er[8*k +: 8] = rw[7:0];
      else if (s == 2'd0) er[7:0] = a[0] ? rw[15:8] : rw[7:0];
      else               er[16*k +: 16] = rw;
      ext_rdata = rw; ext_ack = 1'b1;
      @(negedge clk);
      ext_ack = 1'b0; ext_rdata = 16'h0;
    end
    check("R10 done after last ack", 32'({host_done, ext_req}), 32'b10);
    if (!w) check("R9 read assembly", host_rdata, er);
    @(negedge clk);
    check("R10 done one cycle", 32'({host_done, host_busy}), 32'b00);
  endtask

  task automatic run_fault(input logic n, input logic [1:0] s, input logic [AW-1:0] a);
    @(negedge clk);
    cfg_narrow = n; host_size = s; host_addr = a; host_wr = 1'b1; host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    check("R13 err pulse, no beat", 32'({host_err, ext_req}), 32'b10);
    @(negedge clk);
    check("R13 err ends, no beat", 32'({host_err, ext_req, host_done}), 32'b000);
    @(negedge clk);
    check("R13 still no beat", 32'(ext_req), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_narrow = 1'b0; host_req = 1'b0; host_wr = 1'b0;
    host_addr = '0; host_size = 2'd0; host_wdata = '0; ext_ack = 1'b0; ext_rdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({ext_req, host_done, host_err, host_busy, ext_be_n}), 32'b000011);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after release", 32'({ext_req, host_done, host_err, host_busy, ext_be_n}), 32'b000011);

    for (int v = 0; v < NV; v++) begin
      run_access(VEC[v][45], VEC[v][44:43], AW'(VEC[v][42:35]), VEC[v][34],
                 VEC[v][33:2], int'(VEC[v][1:0]));
    end

    run_fault(1'b0, 2'd1, 32'h41);
    run_fault(1'b0, 2'd2, 32'h42);
    run_fault(1'b1, 2'd2, 32'h43);
    run_fault(1'b1, 2'd3, 32'h40);

    // R12: request held during a narrow longword access is ignored
    @(negedge clk);
    cfg_narrow = 1'b1; host_size = 2'd2; host_addr = 32'h60; host_wr = 1'b1;
    host_wdata = 32'hA4A3_A2A1; host_req = 1'b1;
    @(negedge clk);
    host_addr = 32'h71; host_size = 2'd0; host_wdata = 32'hFF; cfg_narrow = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R12 busy during access", 32'(host_busy), 32'd1);
      check("R12 original beat addr", ext_addr, 32'h60 + 32'(k));
      check("R12 original beat data", 32'(ext_wdata), 32'({8'h00, 8'hA1 + 8'(k)}));
      ext_ack = 1'b1;
      @(negedge clk);
      ext_ack = 1'b0;
    end
    check("R12 done of original", 32'(host_done), 32'd1);
    host_req = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check("R12 no extra beat", 32'({ext_req, host_busy}), 32'b00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule